// File: doc/BRIEF.md
# Integer Dot-Product Instruction Decoder

This block turns one 32-bit vector instruction word into the control bundle for an 8-bit integer dot-product operation. Each 32-bit lane of the destination takes four byte products. The decoder knows two encodings. In the lane-wise form, each lane of the first source pairs with the same lane of the second source. In the indexed form, one 32-bit group of the second source, chosen by a two-bit index, is broadcast to every lane.

A single two-bit field picks signedness and vector width together. In the indexed form, the fifth bit of the second source register number and both bits of the group index come from bits that are spread across the word. A word that matches neither encoding is flagged as undefined. A matching word seen while the feature enable is low is flagged the same way. The decode is combinational and is registered once whenever the input strobe is high. A separate status output mirrors the feature enable so that software-visible capability logic can report it.

Top module: `dot_decode`

## Requirements
- R1: Lane-wise form: a word with bit 31 = 0, bits 28:24 = 5'b01110, bit 21 = 0, bits 15:11 = 5'h12 and bit 10 = 1 decodes, when enabled, to ok = 1, undef = 0, by_elem = 0, rm = bits 20:16 and idx = 0.
- R2: Indexed form: a word with bit 31 = 0, bits 28:24 = 5'b01111, bits 15:12 = 4'hE and bit 10 = 0 decodes, when enabled, to ok = 1, by_elem = 1, rm = {bit 20, bits 19:16} and idx = {bit 11, bit 21}, so idx ranges over 0 to 3.
- R3: For an accepted word, bit 29 drives the unsigned select (1 = unsigned, 0 = signed) and bit 30 drives the width select (1 = 128-bit, 0 = 64-bit). All four combinations of bits 30:29 are accepted.
- R4: For an accepted word of either form, rd = bits 4:0, rn = bits 9:5 and size = bits 23:22.
- R5: A word that matches neither form gives undef = 1, ok = 0, and zero on every field output.
- R6: A word of either form presented while feat_en_i = 0 gives undef = 1, ok = 0, and zero on every field output.
- R7: The outputs change only on a clock edge where in_vld is high. out_vld_o is high in the cycle after such an edge and low otherwise, and the decode outputs hold their value while in_vld is low.
- R8: cap_o equals feat_en_i at all times, with no clock delay.
- R9: While reset is held, out_vld_o, dot_ok_o, undef_o and every field output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Instruction word strobe |
| instr_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Dot-product feature enable |
| out_vld_o | output | 1 | Decode result valid, one cycle after in_vld |
| dot_ok_o | output | 1 | Word is an accepted dot-product operation |
| undef_o | output | 1 | Word is undefined |
| uns_o | output | 1 | 1 = unsigned bytes, 0 = signed |
| wide_o | output | 1 | 1 = 128-bit vector, 0 = 64-bit |
| by_elem_o | output | 1 | 1 = indexed form |
| rd_o | output | 5 | Destination (accumulator) register number |
| rn_o | output | 5 | First source register number |
| rm_o | output | 5 | Second source register number |
| idx_o | output | 2 | Group index for the indexed form |
| size_o | output | 2 | Size field passed through |
| cap_o | output | 1 | Capability status, mirrors feat_en_i |

## Verification
The bench builds the decoder with its default parameters: 32-bit words, 5-bit register numbers and a 2-bit group index. With these values, every index value 0 to 3 and register numbers above 15 in the indexed form can be reached, so the scattered index bits and the high register bit are each exercised in both states. Directed words cover all four sign/width selects in both forms and single-bit departures from each fixed pattern. A random mix of well-formed, malformed and disabled words is then sent back to back, and idle gaps check that the outputs hold.

// File: rtl/dot_decode_pkg.sv
package dot_decode_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_W     = 5;
    localparam int IDX_W     = 2;
    localparam int SIZE_W    = 2;
    localparam int NUM_FORMS = 2;
    localparam int FORM_VEC  = 0;
    localparam int FORM_ELEM = 1;

    // Fixed-bit patterns of each encoding; bits 30:29 stay free (select).
    localparam logic [INSTR_W-1:0] VEC_MASK   = 32'h9F20_FC00;
    localparam logic [INSTR_W-1:0] VEC_VALUE  = 32'h0E00_9400;
    localparam logic [INSTR_W-1:0] ELEM_MASK  = 32'h9F00_F400;
    localparam logic [INSTR_W-1:0] ELEM_VALUE = 32'h0F00_E000;

    typedef struct packed {
        logic              ok;
        logic              undef;
        logic              uns;
        logic              wide;
        logic              by_elem;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rn;
        logic [REG_W-1:0]  rm;
        logic [IDX_W-1:0]  idx;
        logic [SIZE_W-1:0] size;
    } dec_t;

    typedef struct packed {
        logic vld;
        dec_t dec;
    } state_t;

    function automatic logic [INSTR_W-1:0] form_mask(input int f);
        return (f == FORM_ELEM) ? ELEM_MASK : VEC_MASK;
    endfunction

    function automatic logic [INSTR_W-1:0] form_value(input int f);
        return (f == FORM_ELEM) ? ELEM_VALUE : VEC_VALUE;
    endfunction

endpackage

// File: rtl/dot_decode_match.sv
module dot_decode_match #(
    parameter int             W     = 32,
    parameter logic [W-1:0]   MASK  = '0,
    parameter logic [W-1:0]   VALUE = '0
) (
    input  logic [W-1:0] word_i,
    output logic         hit_o
);

    logic [W-1:0] masked;

    always_comb begin
        masked = word_i & MASK;
        hit_o  = (masked == VALUE);
    end

endmodule

// File: rtl/dot_decode_fields.sv
module dot_decode_fields
    import dot_decode_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   rn_o,
    output logic [REG_W-1:0]   rm_vec_o,
    output logic [REG_W-1:0]   rm_elem_o,
    output logic [IDX_W-1:0]   idx_elem_o,
    output logic [SIZE_W-1:0]  size_o,
    output logic               uns_o,
    output logic               wide_o
);

    // Select pair: width bit above, unsigned bit below.
    logic [1:0] sel;

    always_comb begin
        sel        = word_i[30:29];
        wide_o     = sel[1];
        uns_o      = sel[0];
        rd_o       = word_i[4:0];
        rn_o       = word_i[9:5];
        size_o     = word_i[23:22];
        rm_vec_o   = word_i[20:16];
        // Indexed form: high register bit and index bits are scattered.
        rm_elem_o  = {word_i[20], word_i[19:16]};
        idx_elem_o = {word_i[11], word_i[21]};
    end

endmodule

// File: rtl/dot_decode.sv
module dot_decode
    import dot_decode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               feat_en_i,
    output logic               out_vld_o,
    output logic               dot_ok_o,
    output logic               undef_o,
    output logic               uns_o,
    output logic               wide_o,
    output logic               by_elem_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   rn_o,
    output logic [REG_W-1:0]   rm_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [SIZE_W-1:0]  size_o,
    output logic               cap_o
);

    logic [NUM_FORMS-1:0] hit;

    for (genvar f = 0; f < NUM_FORMS; f++) begin : g_form
        dot_decode_match #(
            .W     (INSTR_W),
            .MASK  (form_mask(f)),
            .VALUE (form_value(f))
        ) match_i (
            .word_i (instr_i),
            .hit_o  (hit[f])
        );
    end

    logic [REG_W-1:0]  f_rd, f_rn, f_rm_vec, f_rm_elem;
    logic [IDX_W-1:0]  f_idx;
    logic [SIZE_W-1:0] f_size;
    logic              f_uns, f_wide;

    dot_decode_fields fields_i (
        .word_i     (instr_i),
        .rd_o       (f_rd),
        .rn_o       (f_rn),
        .rm_vec_o   (f_rm_vec),
        .rm_elem_o  (f_rm_elem),
        .idx_elem_o (f_idx),
        .size_o     (f_size),
        .uns_o      (f_uns),
        .wide_o     (f_wide)
    );

    state_t state_d, state_q;
    dec_t   nxt;

    always_comb begin
        nxt = '0;
        if ((|hit) && feat_en_i) begin
            nxt.ok      = 1'b1;
            nxt.uns     = f_uns;
            nxt.wide    = f_wide;
            nxt.by_elem = hit[FORM_ELEM];
            nxt.rd      = f_rd;
            nxt.rn      = f_rn;
            nxt.size    = f_size;
            nxt.rm      = hit[FORM_ELEM] ? f_rm_elem : f_rm_vec;
            nxt.idx     = hit[FORM_ELEM] ? f_idx : '0;
        end else begin
            nxt.undef   = 1'b1;
        end
        state_d.vld = in_vld;
        state_d.dec = in_vld ? nxt : state_q.dec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld_o = state_q.vld;
    assign dot_ok_o  = state_q.dec.ok;
    assign undef_o   = state_q.dec.undef;
    assign uns_o     = state_q.dec.uns;
    assign wide_o    = state_q.dec.wide;
    assign by_elem_o = state_q.dec.by_elem;
    assign rd_o      = state_q.dec.rd;
    assign rn_o      = state_q.dec.rn;
    assign rm_o      = state_q.dec.rm;
    assign idx_o     = state_q.dec.idx;
    assign size_o    = state_q.dec.size;
    assign cap_o     = feat_en_i;

endmodule

// File: rtl/dot_decode_chk.sv
module dot_decode_chk
    import dot_decode_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_vld,
    input logic [INSTR_W-1:0] instr_i,
    input logic               feat_en_i,
    input logic               out_vld_o,
    input logic               dot_ok_o,
    input logic               undef_o,
    input logic               uns_o,
    input logic               wide_o,
    input logic               by_elem_o,
    input logic [REG_W-1:0]   rd_o,
    input logic [IDX_W-1:0]   idx_o,
    input logic               cap_o
);

    // R7
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld_o);

    // R7
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld_o && $stable(rd_o) && $stable(dot_ok_o) && $stable(idx_o)));

    // R5
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (dot_ok_o != undef_o));

    // R6
    feat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !feat_en_i) |=> (undef_o && !dot_ok_o));

    // R3
    sign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (!dot_ok_o || (uns_o == $past(instr_i[29]) && wide_o == $past(instr_i[30]))));

    // R1
    vec_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && dot_ok_o && !by_elem_o) |-> (idx_o == '0));

    // R8
    always_comb begin
        cap_mirror_chk: assert (cap_o == feat_en_i);
    end

endmodule

bind dot_decode dot_decode_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .instr_i   (instr_i),
    .feat_en_i (feat_en_i),
    .out_vld_o (out_vld_o),
    .dot_ok_o  (dot_ok_o),
    .undef_o   (undef_o),
    .uns_o     (uns_o),
    .wide_o    (wide_o),
    .by_elem_o (by_elem_o),
    .rd_o      (rd_o),
    .idx_o     (idx_o),
    .cap_o     (cap_o)
);

// File: tb/dot_decode_tb_top.sv
`timescale 1ns/1ps
module dot_decode_tb_top;

    typedef struct packed {
        logic       ok;
        logic       undef;
        logic       uns;
        logic       wide;
        logic       by_elem;
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
        logic [1:0] idx;
        logic [1:0] size;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] instr = '0;
    logic        fe = 1'b1;
    logic        out_vld, dot_ok, undef, uns, wide, by_elem, cap;
    logic [4:0]  rd, rn, rm;
    logic [1:0]  idx, size;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];
    exp_t last_exp = '0;

    always #2.5 clk = ~clk;

    dot_decode dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr_i(instr),
        .feat_en_i(fe), .out_vld_o(out_vld), .dot_ok_o(dot_ok),
        .undef_o(undef), .uns_o(uns), .wide_o(wide), .by_elem_o(by_elem),
        .rd_o(rd), .rn_o(rn), .rm_o(rm), .idx_o(idx), .size_o(size),
        .cap_o(cap)
    );

    function automatic logic [31:0] mk_vec(bit q1, bit u, logic [1:0] sz,
                                           logic [4:0] m, logic [4:0] n, logic [4:0] d);
        return {1'b0, q1, u, 5'b01110, sz, 1'b0, m, 5'h12, 1'b1, n, d};
    endfunction

    function automatic logic [31:0] mk_elem(bit q1, bit u, logic [1:0] sz, bit l, bit mh,
                                            logic [3:0] m, bit h, logic [4:0] n, logic [4:0] d);
        return {1'b0, q1, u, 5'b01111, sz, l, mh, m, 4'hE, h, 1'b0, n, d};
    endfunction

    function automatic exp_t model(logic [31:0] w, logic en);
        exp_t e = '0;
        bit is_vec  = (w[31] == 1'b0) && (w[28:24] == 5'b01110) && !w[21]
                      && (w[15:11] == 5'h12) && w[10];
        bit is_elem = (w[31] == 1'b0) && (w[28:24] == 5'b01111)
                      && (w[15:12] == 4'hE) && !w[10];
        if ((is_vec || is_elem) && en) begin
            e.ok = 1'b1; e.uns = w[29]; e.wide = w[30]; e.by_elem = is_elem;
            e.rd = w[4:0]; e.rn = w[9:5]; e.size = w[23:22];
            if (is_elem) begin
                e.rm  = {w[20], w[19:16]};
                e.idx = {w[11], w[21]};
            end else begin
                e.rm  = w[20:16];
            end
        end else begin
            e.undef = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(exp_t e, logic [31:0] w, logic en);
        if (e.ok) return e.by_elem ? "R2" : "R1";
        if (!en && model(w, 1'b1).ok) return "R6";
        return "R5";
    endfunction

    task automatic drive(logic [31:0] w, logic en);
        exp_t e;
        @(negedge clk);
        instr = w; fe = en; in_vld = 1'b1;
        e = model(w, en);
        q.push_back(e);
    endtask

    task automatic idle_hold_check();
        @(negedge clk);
        in_vld = 1'b0;
        instr = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || {dot_ok, undef, uns, wide, by_elem, rd, rn, rm, idx, size} !== last_exp) begin
            errors++;
            $display("FAIL R7 hold: vld=%b out=%h exp=%h", out_vld,
                     {dot_ok, undef, uns, wide, by_elem, rd, rn, rm, idx, size}, last_exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            exp_t e;
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected out_vld: got 1 expected 0");
            end else begin
                e = q.pop_front();
                last_exp = e;
                checks++;
                if (dot_ok !== e.ok || undef !== e.undef || by_elem !== e.by_elem ||
                    rm !== e.rm || idx !== e.idx) begin
                    errors++;
                    $display("FAIL %s core: got ok=%b und=%b be=%b rm=%0d idx=%0d expected ok=%b und=%b be=%b rm=%0d idx=%0d",
                             e.ok ? (e.by_elem ? "R2" : "R1") : "R5/R6",
                             dot_ok, undef, by_elem, rm, idx, e.ok, e.undef, e.by_elem, e.rm, e.idx);
                end
                checks++;
                if (uns !== e.uns || wide !== e.wide) begin
                    errors++;
                    $display("FAIL R3 select: got uns=%b wide=%b expected uns=%b wide=%b",
                             uns, wide, e.uns, e.wide);
                end
                checks++;
                if (rd !== e.rd || rn !== e.rn || size !== e.size) begin
                    errors++;
                    $display("FAIL R4 fields: got rd=%0d rn=%0d sz=%0d expected rd=%0d rn=%0d sz=%0d",
                             rd, rn, size, e.rd, e.rn, e.size);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        instr = mk_vec(1'b1, 1'b1, 2'b10, 5'd3, 5'd4, 5'd5);
        in_vld = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_vld, dot_ok, undef, uns, wide, by_elem, rd, rn, rm, idx, size} !== '0) begin
            errors++;
            $display("FAIL R9 reset: got %h expected 0",
                     {out_vld, dot_ok, undef, uns, wide, by_elem, rd, rn, rm, idx, size});
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8 capability mirror
        for (int k = 0; k < 2; k++) begin
            fe = k[0];
            #1;
            checks++;
            if (cap !== fe) begin
                errors++;
                $display("FAIL R8 cap: got %b expected %b", cap, fe);
            end
        end
        fe = 1'b1;

        // R1/R3 lane-wise form, all four selects
        for (int s = 0; s < 4; s++)
            drive(mk_vec(s[1], s[0], 2'b10, 5'd17 + 5'(s), 5'd2 + 5'(s), 5'd31 - 5'(s)), 1'b1);
        // R2/R3 indexed form, every index, high register bit both ways
        for (int s = 0; s < 8; s++)
            drive(mk_elem(s[1], s[0], 2'(s), s[0], s[2], 4'(s * 3), s[1], 5'd9, 5'(s + 20)), 1'b1);
        idle_hold_check();

        // R5 malformed words: one fixed bit off in each pattern
        drive(32'h0, 1'b1);
        drive(mk_vec(1'b0, 1'b0, 2'b10, 5'd1, 5'd1, 5'd1) | 32'h8000_0000, 1'b1);
        drive(mk_vec(1'b0, 1'b1, 2'b10, 5'd1, 5'd1, 5'd1) ^ 32'h0000_0800, 1'b1);
        drive(mk_vec(1'b1, 1'b0, 2'b10, 5'd1, 5'd1, 5'd1) | 32'h0020_0000, 1'b1);
        drive(mk_vec(1'b1, 1'b1, 2'b10, 5'd1, 5'd1, 5'd1) ^ 32'h0000_0400, 1'b1);
        drive(mk_elem(1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 4'hF, 1'b1, 5'd7, 5'd8) ^ 32'h0000_1000, 1'b1);
        drive(mk_elem(1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 4'hF, 1'b1, 5'd7, 5'd8) | 32'h0000_0400, 1'b1);
        idle_hold_check();

        // R6 feature disabled
        drive(mk_vec(1'b1, 1'b0, 2'b10, 5'd6, 5'd7, 5'd8), 1'b0);
        drive(mk_elem(1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 4'h3, 1'b1, 5'd7, 5'd8), 1'b0);
        drive(mk_vec(1'b1, 1'b0, 2'b10, 5'd6, 5'd7, 5'd8), 1'b1);
        idle_hold_check();

        // Random mix, back to back
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r = $urandom;
            logic [2:0]  pick = 3'($urandom_range(0, 7));
            logic        en = ($urandom_range(0, 3) != 0);
            if (pick < 3)
                drive(mk_vec(r[30], r[29], r[23:22], r[20:16], r[9:5], r[4:0]), en);
            else if (pick < 6)
                drive(mk_elem(r[30], r[29], r[23:22], r[21], r[20], r[19:16], r[11], r[9:5], r[4:0]), en);
            else
                drive(r, en);
            if (k % 97 == 0) idle_hold_check();
        end
        idle_hold_check();

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7 pending results: got %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule